// File: doc/BRIEF.md
# Dual-Channel Fast Over-Range Detector

This block watches the 13-bit sample magnitude of two converter channels and raises fast flags that report when a sample is large or small. Each channel is tested against three limits in parallel. The first is a coarse upper limit picked by a 3-bit code that selects a power of two. The second is a fine 13-bit upper limit. The third is a fine 13-bit lower limit. The three results form a 3-bit flag word for that channel. A second presentation mode shows the three most significant magnitude bits in place of the flags.

Each channel has its own set of three flag pins and an enable that models the high-impedance state. In the shared mode, both channels use the channel A pins. Channel A appears on even cycles and channel B on odd cycles. If only one channel is active, that channel repeats on every cycle. If neither channel is active, the shared pins go to high impedance. All limits and modes are set through a byte-wide write port.

Top module: `fast_overrange_det`

## Requirements
- R1: The write port maps as follows. Address 0 is control: bit 0 enables the outputs, bits 3:1 select the mode, and bit 4 selects the shared mode. Address 1 bits 2:0 hold the coarse code. Addresses 2 and 3 hold the fine upper limit, with the low byte at 2 and bits 12:8 in bits 4:0 of address 3. Addresses 4 and 5 hold the fine lower limit in the same split layout. Bits 7:5 of addresses 3 and 5 are ignored.
- R2: The fine-upper flag (bit 1 of a flag word) is 1 exactly when the magnitude is strictly greater than the fine upper limit.
- R3: The fine-lower flag (bit 0 of a flag word) is 1 exactly when the magnitude is strictly less than the fine lower limit.
- R4: The coarse flag (bit 2 of a flag word) is 1 when the magnitude is at or above the coarse threshold. For code c from 0 to 6 the threshold is 2^(12-c), and for code 7 it is 1.
- R5: Mode code 1 presents magnitude bits 12:10 on the pins. Every other mode code presents the flag word.
- R6: While the enable bit is 0, both pin sets are in high impedance (enable 0) and their data is 0.
- R7: In separate mode, each output is registered and reflects the inputs of the previous clock edge. A channel's pin enable equals that channel's active input.
- R8: In shared mode with both channels active, the channel A pins carry channel A on even cycles and channel B on odd cycles. Cycles are counted from 0 at the first edge after reset. The channel B pins are in high impedance.
- R9: In shared mode with exactly one channel active, the channel A pins repeat that channel on every cycle.
- R10: In shared mode with neither channel active, the channel A pins are in high impedance.
- R11: Reset clears every configuration field to 0 and puts both pin sets in high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| mag_a | input | 13 | Channel A sample magnitude |
| mag_b | input | 13 | Channel B sample magnitude |
| ch_a_on | input | 1 | Channel A active |
| ch_b_on | input | 1 | Channel B active |
| fd_a | output | 3 | Channel A (or shared) fast-detect pins |
| fd_a_en | output | 1 | Drive enable for fd_a; 0 means high impedance |
| fd_b | output | 3 | Channel B fast-detect pins |
| fd_b_en | output | 1 | Drive enable for fd_b; 0 means high impedance |

## Verification
The bench builds the block with its default widths: a 13-bit magnitude and a 3-bit coarse code. This keeps a full magnitude sweep small enough to run. Every one of the 8192 magnitudes is driven for each of the eight coarse codes, with channel B sweeping downward against channel A. Every equality boundary of the coarse, fine-upper and fine-lower compares is therefore hit on both channels. Shorter runs then cover each mode code, and each shared-mode combination of active channels against the bench's own cycle parity.

// File: rtl/fod_pkg.sv
package fod_pkg;
  localparam int PIN_W = 3;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_COARSE = 1;
  localparam int ADR_UP_LO  = 2;
  localparam int ADR_UP_HI  = 3;
  localparam int ADR_LO_LO  = 4;
  localparam int ADR_LO_HI  = 5;
  localparam logic [2:0] MD_MSB = 3'd1;
endpackage

// File: rtl/fod_cfg_regs.sv
module fod_cfg_regs #(
  parameter int MAG_W  = 13,
  parameter int CODE_W = 3,
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              en,
  output logic [2:0]        mode,
  output logic              ilv,
  output logic [CODE_W-1:0] coarse,
  output logic [MAG_W-1:0]  fine_up,
  output logic [MAG_W-1:0]  fine_lo
);
  import fod_pkg::*;
  localparam int HI_W = MAG_W - BYTE_W;

  logic [BYTE_W-1:0] up_lo, lo_lo;
  logic [HI_W-1:0]   up_hi, lo_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; mode <= '0; ilv <= 1'b0; coarse <= '0;
      up_lo <= '0; up_hi <= '0; lo_lo <= '0; lo_hi <= '0;
    end else if (we) begin
      case (int'(addr))
        ADR_CTRL: begin
          en   <= wdata[0];
          mode <= wdata[3:1];
          ilv  <= wdata[4];
        end
        ADR_COARSE: coarse <= wdata[CODE_W-1:0];
        ADR_UP_LO:  up_lo  <= wdata;
        ADR_UP_HI:  up_hi  <= wdata[HI_W-1:0];
        ADR_LO_LO:  lo_lo  <= wdata;
        ADR_LO_HI:  lo_hi  <= wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign fine_up = {up_hi, up_lo};
  assign fine_lo = {lo_hi, lo_lo};
endmodule

// File: rtl/fod_chan_cmp.sv
module fod_chan_cmp #(
  parameter int MAG_W  = 13,
  parameter int CODE_W = 3
) (
  input  logic [MAG_W-1:0]        mag,
  input  logic [CODE_W-1:0]       coarse,
  input  logic [MAG_W-1:0]        fine_up,
  input  logic [MAG_W-1:0]        fine_lo,
  input  logic [2:0]              mode,
  output logic [fod_pkg::PIN_W-1:0] word
);
  import fod_pkg::*;
  localparam int TOP = MAG_W - 1;
  localparam logic [CODE_W-1:0] LAST_CODE = '1;

  logic [MAG_W-1:0] thr;
  int shamt;

  always_comb begin
    shamt = TOP - int'(coarse);
    if (shamt < 0) shamt = 0;
    if (coarse == LAST_CODE) thr = MAG_W'(1);
    else                     thr = MAG_W'(1) << shamt;
  end

  always_comb begin
    if (mode == MD_MSB) word = mag[MAG_W-1 -: PIN_W];
    else word = {mag >= thr, mag > fine_up, mag < fine_lo};
  end
endmodule

// File: rtl/fod_out_stage.sv
module fod_out_stage #(
  parameter int PIN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ilv,
  input  logic [1:0]       ch_on,
  input  logic [PIN_W-1:0] word_a,
  input  logic [PIN_W-1:0] word_b,
  output logic [PIN_W-1:0] fd_a,
  output logic             fd_a_en,
  output logic [PIN_W-1:0] fd_b,
  output logic             fd_b_en
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      fd_a <= '0; fd_a_en <= 1'b0;
      fd_b <= '0; fd_b_en <= 1'b0;
    end else begin
      phase <= ~phase;
      if (!en) begin
        fd_a <= '0; fd_a_en <= 1'b0;
        fd_b <= '0; fd_b_en <= 1'b0;
      end else if (ilv) begin
        fd_b <= '0; fd_b_en <= 1'b0;
        case (ch_on)
          2'b11:   begin fd_a <= phase ? word_b : word_a; fd_a_en <= 1'b1; end
          2'b01:   begin fd_a <= word_a; fd_a_en <= 1'b1; end
          2'b10:   begin fd_a <= word_b; fd_a_en <= 1'b1; end
          default: begin fd_a <= '0;     fd_a_en <= 1'b0; end
        endcase
      end else begin
        fd_a_en <= ch_on[0];
        fd_a    <= ch_on[0] ? word_a : '0;
        fd_b_en <= ch_on[1];
        fd_b    <= ch_on[1] ? word_b : '0;
      end
    end
  end
endmodule

// File: rtl/fast_overrange_det.sv
module fast_overrange_det #(
  parameter int MAG_W  = 13,
  parameter int CODE_W = 3,
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic [MAG_W-1:0]  mag_a,
  input  logic [MAG_W-1:0]  mag_b,
  input  logic              ch_a_on,
  input  logic              ch_b_on,
  output logic [2:0]        fd_a,
  output logic              fd_a_en,
  output logic [2:0]        fd_b,
  output logic              fd_b_en
);
  import fod_pkg::*;
  localparam int NCH = 2;

  logic              cfg_en, cfg_ilv;
  logic [2:0]        cfg_mode;
  logic [CODE_W-1:0] cfg_coarse;
  logic [MAG_W-1:0]  fine_up, fine_lo;
  logic [NCH-1:0][MAG_W-1:0] mags;
  logic [NCH-1:0][PIN_W-1:0] words;

  assign mags = {mag_b, mag_a};

  fod_cfg_regs #(.MAG_W(MAG_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en(cfg_en), .mode(cfg_mode), .ilv(cfg_ilv), .coarse(cfg_coarse),
    .fine_up(fine_up), .fine_lo(fine_lo)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    fod_chan_cmp #(.MAG_W(MAG_W), .CODE_W(CODE_W)) u_cmp (
      .mag(mags[g]), .coarse(cfg_coarse), .fine_up(fine_up), .fine_lo(fine_lo),
      .mode(cfg_mode), .word(words[g])
    );
  end

  fod_out_stage #(.PIN_W(PIN_W)) u_out (
    .clk(clk), .rst(rst), .en(cfg_en), .ilv(cfg_ilv), .ch_on({ch_b_on, ch_a_on}),
    .word_a(words[0]), .word_b(words[1]),
    .fd_a(fd_a), .fd_a_en(fd_a_en), .fd_b(fd_b), .fd_b_en(fd_b_en)
  );
endmodule

// File: rtl/fod_checker.sv
module fod_checker #(
  parameter int MAG_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_ilv,
  input logic [2:0]       cfg_mode,
  input logic [MAG_W-1:0] fine_up,
  input logic [MAG_W-1:0] fine_lo,
  input logic [MAG_W-1:0] mag_a,
  input logic [MAG_W-1:0] mag_b,
  input logic             ch_a_on,
  input logic             ch_b_on,
  input logic [2:0]       fd_a,
  input logic             fd_a_en,
  input logic             fd_b_en
);
  p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (!fd_a_en && !fd_b_en));

  p_shared_pins_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_ilv |=> !fd_b_en);

  p_both_off_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_ilv && !ch_a_on && !ch_b_on) |=> !fd_a_en);

  p_one_on_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_ilv && (ch_a_on != ch_b_on)) |=> fd_a_en);

  p_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !cfg_ilv) |=> (fd_a_en == $past(ch_a_on)));

  p_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !cfg_ilv && ch_a_on && cfg_mode != 3'd1)
      |=> (fd_a[1] == $past(mag_a > fine_up)));

  p_lower_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !cfg_ilv && ch_a_on && cfg_mode != 3'd1)
      |=> (fd_a[0] == $past(mag_a < fine_lo)));

  p_msb_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !cfg_ilv && ch_a_on && cfg_mode == 3'd1)
      |=> (fd_a == $past(mag_a[MAG_W-1 -: 3])));
endmodule

bind fast_overrange_det fod_checker #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_ilv(cfg_ilv), .cfg_mode(cfg_mode),
  .fine_up(fine_up), .fine_lo(fine_lo), .mag_a(mag_a), .mag_b(mag_b),
  .ch_a_on(ch_a_on), .ch_b_on(ch_b_on), .fd_a(fd_a), .fd_a_en(fd_a_en),
  .fd_b_en(fd_b_en)
);

// File: tb/fast_overrange_det_bench.sv
module fast_overrange_det_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [12:0] mag_a = '0, mag_b = '0;
  logic        ch_a_on = 1'b1, ch_b_on = 1'b1;
  logic [2:0]  fd_a, fd_b;
  logic        fd_a_en, fd_b_en;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  fast_overrange_det u_fast_overrange_det (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mag_a(mag_a), .mag_b(mag_b), .ch_a_on(ch_a_on), .ch_b_on(ch_b_on),
    .fd_a(fd_a), .fd_a_en(fd_a_en), .fd_b(fd_b), .fd_b_en(fd_b_en)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic logic [2:0] expw(int m, int c, int fu, int fl, int md);
    int thr;
    logic [2:0] r;
    thr = (c == 7) ? 1 : (1 << (12 - c));
    if (md == 1) begin
      r = 3'((m >> 10) & 7);
    end else begin
      r[2] = (m >= thr);
      r[1] = (m > fu);
      r[0] = (m < fl);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got={en,data}=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic drive(input int ma, input int mb);
    @(negedge clk);
    mag_a = 13'(ma); mag_b = 13'(mb);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int fu, fl;
    bit pa;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R11: outputs disabled after reset
    chk("R11 reset A", {fd_a_en, fd_a}, 4'h0);
    chk("R11 reset B", {fd_b_en, fd_b}, 4'h0);
    // R6: enable still 0 by default, magnitude ignored at the pins
    drive(8191, 8191);
    chk("R6 default off A", {fd_a_en, fd_a}, 4'h0);
    chk("R6 default off B", {fd_b_en, fd_b}, 4'h0);
    // R11: zero thresholds after reset once enabled
    wr(0, 8'h01);
    drive(0, 1);
    chk("R11 zero cfg A", {fd_a_en, fd_a}, {1'b1, expw(0, 0, 0, 0, 0)});
    chk("R11 zero cfg B", {fd_b_en, fd_b}, {1'b1, expw(1, 0, 0, 0, 0)});

    // R1: split layout, reserved high bits ignored
    fu = 13'h0ABC; fl = 13'h0123;
    wr(2, 8'hBC); wr(3, 8'hEA);
    wr(4, 8'h23); wr(5, 8'h21);
    wr(6, 8'hFF); wr(7, 8'hFF);
    // R2 R3 R4 R7: full sweep per coarse code
    for (int c = 0; c < 8; c++) begin
      wr(1, c);
      for (int m = 0; m < 8192; m++) begin
        drive(m, 8191 - m);
        chk("R1 R2 R3 R4 sweep A", {fd_a_en, fd_a}, {1'b1, expw(m, c, fu, fl, 0)});
        chk("R2 R3 R4 R7 sweep B", {fd_b_en, fd_b}, {1'b1, expw(8191 - m, c, fu, fl, 0)});
      end
    end

    // R5: mode 1 shows top bits
    wr(0, 8'h03);
    for (int m = 0; m < 8192; m += 3) begin
      drive(m, 8191 - m);
      chk("R5 msb A", {fd_a_en, fd_a}, {1'b1, expw(m, 7, fu, fl, 1)});
      chk("R5 msb B", {fd_b_en, fd_b}, {1'b1, expw(8191 - m, 7, fu, fl, 1)});
    end
    // R5: other codes behave as flag mode
    wr(1, 3);
    for (int md = 2; md < 8; md++) begin
      wr(0, 1 | (md << 1));
      for (int m = 0; m < 8192; m += 97) begin
        drive(m, fu + 1);
        chk("R5 other mode A", {fd_a_en, fd_a}, {1'b1, expw(m, 3, fu, fl, 0)});
        chk("R5 other mode B", {fd_b_en, fd_b}, {1'b1, expw(fu + 1, 3, fu, fl, 0)});
      end
    end

    // R7: per-channel enable follows active inputs
    wr(0, 8'h01);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ch_a_on = k[0]; ch_b_on = k[1];
      mag_a = 13'(k * 1000); mag_b = 13'(5000 - k * 700);
      @(posedge clk); #1;
      chk("R7 sep A", {fd_a_en, fd_a}, k[0] ? {1'b1, expw(k * 1000, 3, fu, fl, 0)} : 4'h0);
      chk("R7 sep B", {fd_b_en, fd_b}, k[1] ? {1'b1, expw(5000 - k * 700, 3, fu, fl, 0)} : 4'h0);
    end

    // R8 R9 R10: shared pins
    wr(0, 8'h11);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ch_a_on = k[0]; ch_b_on = k[1];
      for (int s = 0; s < 12; s++) begin
        int va, vb;
        logic [3:0] e;
        va = (s * 691 + 17) % 8192;
        vb = (8000 - s * 587 + 8192) % 8192;
        drive(va, vb);
        pa = ((cyc - 1) % 2) == 0;
        case (k)
          3: e = {1'b1, pa ? expw(va, 3, fu, fl, 0) : expw(vb, 3, fu, fl, 0)};
          1: e = {1'b1, expw(va, 3, fu, fl, 0)};
          2: e = {1'b1, expw(vb, 3, fu, fl, 0)};
          default: e = 4'h0;
        endcase
        if (k == 3) chk("R8 alternate", {fd_a_en, fd_a}, e);
        else if (k == 0) chk("R10 both off", {fd_a_en, fd_a}, e);
        else chk("R9 repeat active", {fd_a_en, fd_a}, e);
        chk("R8 B pins hiz", {fd_b_en, fd_b}, 4'h0);
      end
    end

    // R6: clearing enable puts both pin sets in high impedance
    ch_a_on = 1'b1; ch_b_on = 1'b1;
    wr(0, 8'h10);
    for (int s = 0; s < 4; s++) begin
      drive(8191, 0);
      chk("R6 off A", {fd_a_en, fd_a}, 4'h0);
      chk("R6 off B", {fd_b_en, fd_b}, 4'h0);
    end
    finish_run();
  end
endmodule